// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words. The producer and the consumer run on unrelated clocks. Words enter on the write clock and leave on the read clock. The depth is a parameter and must be a power of two of at least 16; the default is 256. Four active-low flags tell each side how much room or data is left:

- `full_n` and `afull_n` are on the write side.
- `empty_n` and `aempty_n` are on the read side.

Each flag is produced in the clock domain of the side it throttles, so a producer or consumer can act on it the cycle it sees it.

The two thresholds are held in offset registers and both reset to 7:

- The almost-full offset `m` pulls `afull_n` low once the count reaches DEPTH−m.
- The almost-empty offset `n` keeps `aempty_n` low while the count is n or less.

Software loads the offsets through a small strobe port clocked by the write clock. A load is taken only while the buffer is drained.

Read and write pointers are one bit wider than the address. Each pointer crosses to the other domain as Gray code through a two-flop synchroniser. Each side holds a three-state flag machine whose state register drives its flags.

The write side machine has three states:
- WS_OPEN: fewer than DEPTH−m words.
- WS_NEAR: between DEPTH−m and DEPTH−1 words.
- WS_FULL: DEPTH words.

The read side machine has three states:
- RS_EMPTY: no words.
- RS_LOW: 1 to n words.
- RS_OPEN: more than n words.

Transitions:
- Write side: grow (OPEN→NEAR, NEAR→FULL) is taken on a write. Shrink (FULL→NEAR, FULL→OPEN, NEAR→OPEN) is taken when the synchronised read pointer advances.
- Read side: fill (EMPTY→LOW, LOW→OPEN, EMPTY→OPEN) is taken when the synchronised write pointer advances. Drain (OPEN→LOW, LOW→EMPTY, OPEN→EMPTY) is taken on a read.

Top module: `pfifo_pflag`

## Requirements
- R1: Words leave in the order they were accepted, bit for bit. `rd_data` is registered: it changes only on a read-clock edge where `rd_en` is high and `empty_n` is high, and otherwise holds its value.
- R2: `full_n` is low exactly when DEPTH words are stored. It falls on the write-clock edge that accepts the DEPTH-th word. A write presented while `full_n` is low stores nothing and leaves every stored word unchanged.
- R3: `empty_n` is low exactly when no words are stored. A read presented while `empty_n` is low changes neither `rd_data` nor the stored words.
- R4: `afull_n` is low when the word count is between DEPTH−m and DEPTH inclusive, and high below DEPTH−m.
- R5: `aempty_n` is low when the word count is between 0 and n inclusive, and high from n+1 words upward.
- R6: After reset, the flags are driven as follows and both offsets hold 7:
  - `empty_n` = 0
  - `aempty_n` = 0
  - `full_n` = 1
  - `afull_n` = 1
- R7: A write-clock edge with `cfg_ld` high loads `cfg_val` into one offset register, selected by `cfg_sel`:
  - `cfg_sel` = 0 selects the almost-empty offset n.
  - `cfg_sel` = 1 selects the almost-full offset m.

  The load is taken only while the write side sees zero stored words; otherwise it is ignored.
- R8: A loaded offset is clamped to the range 1 to DEPTH−2. A value of 0 becomes 1; DEPTH−1 becomes DEPTH−2.
- R9: A write is reflected in `empty_n` and `aempty_n` within three read-clock rising edges. A read is reflected in `full_n` and `afull_n` within three write-clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Word to store |
| full_n | output | 1 | Low when DEPTH words are stored |
| afull_n | output | 1 | Low when at least DEPTH−m words are stored |
| rclk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 9 | Last word read |
| empty_n | output | 1 | Low when no words are stored |
| aempty_n | output | 1 | Low when n or fewer words are stored |
| cfg_ld | input | 1 | Offset load strobe, write clock domain |
| cfg_sel | input | 1 | 0 selects offset n, 1 selects offset m |
| cfg_val | input | log2(DEPTH) | Offset value to load |

## Verification
A wrong state in this block shows at the ports in two ways. A corrupted pointer or Gray crossing reorders, drops or repeats data at `rd_data`. A miscounting flag machine leaves a flag wrong for good once the other side's pointer has settled, which takes at most three cycles of the flag's own clock. So the flags are compared against the threshold table after every single word, over a full fill and drain, for several offset pairs including both clamped extremes. Each flag check runs after a settling window longer than the synchroniser latency. Free-running traffic on unrelated clocks then checks ordering against a queue model while both pointers move.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;
    localparam int DATA_W = 9;

    typedef enum logic [1:0] {
        WS_OPEN = 2'd0,
        WS_NEAR = 2'd1,
        WS_FULL = 2'd2
    } wstate_e;

    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_LOW   = 2'd1,
        RS_OPEN  = 2'd2
    } rstate_e;
endpackage

// File: rtl/pfifo_sync.sv
module pfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of the gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_bin
        assign bin_out[i] = ^(stage2 >> i);
    end
endmodule

// File: rtl/pfifo_ofs.sv
module pfifo_ofs #(
    parameter int DEPTH   = 256,
    parameter int DEF_OFS = 7,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          cfg_ld,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_val,
    input  logic          idle,
    output logic [AW-1:0] ofs_n,
    output logic [AW-1:0] ofs_m
);
    localparam logic [AW-1:0] OFS_MAX = AW'(DEPTH - 2);
    localparam logic [AW-1:0] OFS_MIN = AW'(1);
    localparam logic [AW-1:0] OFS_RST = AW'(DEF_OFS);

    function automatic logic [AW-1:0] clamp(input logic [AW-1:0] v);
        if (v < OFS_MIN)      return OFS_MIN;
        else if (v > OFS_MAX) return OFS_MAX;
        else                  return v;
    endfunction

    logic take;
    assign take = cfg_ld && idle;

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_n <= OFS_RST;
            ofs_m <= OFS_RST;
        end else if (take) begin
            if (cfg_sel) ofs_m <= clamp(cfg_val);
            else         ofs_n <= clamp(cfg_val);
        end
    end

    p_ofs_range_r8: assert property (@(posedge wclk) disable iff (!rst_n)
        (ofs_n >= OFS_MIN) && (ofs_n <= OFS_MAX) && (ofs_m >= OFS_MIN) && (ofs_m <= OFS_MAX));

    p_cfg_ignored_r7: assert property (@(posedge wclk) disable iff (!rst_n)
        (cfg_ld && !idle) |=> ($stable(ofs_n) && $stable(ofs_m)));
endmodule

// File: rtl/pfifo_wside.sv
module pfifo_wside
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW:0]   rsync_bin,
    input  logic [AW-1:0] ofs_m,
    output logic          wfire,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          idle,
    output logic          full_n,
    output logic          afull_n
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    wstate_e     state, state_nx;
    logic [AW:0] wbin, wbin_nx, wcnt_nx;
    logic        at_full, at_near;

    assign wfire   = wr_en && (state != WS_FULL);
    assign wbin_nx = wbin + {{AW{1'b0}}, wfire};
    assign wcnt_nx = wbin_nx - rsync_bin;
    assign at_full = (wcnt_nx == DEPTH_V);
    assign at_near = (wcnt_nx >= (DEPTH_V - {1'b0, ofs_m}));
    assign waddr   = wbin[AW-1:0];
    assign idle    = (wbin == rsync_bin);

    // Next state: grow on write, shrink when the synchronised read pointer advances
    always_comb begin
        if (at_full)      state_nx = WS_FULL;
        else if (at_near) state_nx = WS_NEAR;
        else              state_nx = WS_OPEN;
    end

    // State register with pointer registers
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_OPEN;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            state <= state_nx;
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        unique case (state)
            WS_OPEN: begin full_n = 1'b1; afull_n = 1'b1; end
            WS_NEAR: begin full_n = 1'b1; afull_n = 1'b0; end
            WS_FULL: begin full_n = 1'b0; afull_n = 1'b0; end
            default: begin full_n = 1'b1; afull_n = 1'b1; end
        endcase
    end

    p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wbin - rsync_bin) <= DEPTH_V);

    p_full_block_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && !full_n) |=> (wbin == $past(wbin)));

    p_full_in_afull_r4: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);
endmodule

// File: rtl/pfifo_rside.sv
module pfifo_rside
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW:0]   wsync_bin,
    input  logic [AW-1:0] ofs_n,
    output logic          rfire,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    rstate_e     state, state_nx;
    logic [AW:0] rbin, rbin_nx, rcnt_nx;
    logic        at_empty, at_low;

    assign rfire    = rd_en && (state != RS_EMPTY);
    assign rbin_nx  = rbin + {{AW{1'b0}}, rfire};
    assign rcnt_nx  = wsync_bin - rbin_nx;
    assign at_empty = (rcnt_nx == '0);
    assign at_low   = (rcnt_nx <= {1'b0, ofs_n});
    assign raddr    = rbin[AW-1:0];

    // Next state: drain on read, fill when the synchronised write pointer advances
    always_comb begin
        if (at_empty)    state_nx = RS_EMPTY;
        else if (at_low) state_nx = RS_LOW;
        else             state_nx = RS_OPEN;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_EMPTY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            state <= state_nx;
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_comb begin
        unique case (state)
            RS_EMPTY: begin empty_n = 1'b0; aempty_n = 1'b0; end
            RS_LOW:   begin empty_n = 1'b1; aempty_n = 1'b0; end
            RS_OPEN:  begin empty_n = 1'b1; aempty_n = 1'b1; end
            default:  begin empty_n = 1'b0; aempty_n = 1'b0; end
        endcase
    end

    p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        (wsync_bin - rbin) <= DEPTH_V);

    p_empty_block_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_en && !empty_n) |=> (rbin == $past(rbin)));

    p_empty_in_aempty_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

// File: rtl/pfifo_pflag.sv
module pfifo_pflag
    import pfifo_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int DEF_OFS = 7
) (
    input  logic                     rst_n,
    input  logic                     wclk,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     full_n,
    output logic                     afull_n,
    input  logic                     rclk,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     empty_n,
    output logic                     aempty_n,
    input  logic                     cfg_ld,
    input  logic                     cfg_sel,
    input  logic [$clog2(DEPTH)-1:0] cfg_val
);
    localparam int AW = $clog2(DEPTH);

    logic              wfire, rfire, idle;
    logic [AW-1:0]     waddr, raddr, ofs_n, ofs_m;
    logic [AW:0]       wgray, rgray, wsync_bin, rsync_bin;
    logic [DATA_W-1:0] mem [DEPTH];

    pfifo_ofs #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) ofs_i (
        .wclk(wclk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_sel(cfg_sel),
        .cfg_val(cfg_val), .idle(idle), .ofs_n(ofs_n), .ofs_m(ofs_m)
    );

    pfifo_wside #(.DEPTH(DEPTH)) wside_i (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .rsync_bin(rsync_bin),
        .ofs_m(ofs_m), .wfire(wfire), .waddr(waddr), .wgray(wgray),
        .idle(idle), .full_n(full_n), .afull_n(afull_n)
    );

    pfifo_rside #(.DEPTH(DEPTH)) rside_i (
        .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .wsync_bin(wsync_bin),
        .ofs_n(ofs_n), .rfire(rfire), .raddr(raddr), .rgray(rgray),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    pfifo_sync #(.W(AW+1)) w2r_i (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wsync_bin)
    );

    pfifo_sync #(.W(AW+1)) r2w_i (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rsync_bin)
    );

    always_ff @(posedge wclk) begin
        if (wfire) mem[waddr] <= wr_data;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rfire) rd_data <= mem[raddr];
    end

    p_rdata_hold_r1: assert property (@(posedge rclk) disable iff (!rst_n)
        !rfire |=> $stable(rd_data));
endmodule

// File: tb/pfifo_pflag_tb_top.sv
module pfifo_pflag_tb_top;
    localparam int DEPTH   = 16;
    localparam int AW      = 4;
    localparam int CLK_W   = 10;
    localparam int CLK_R   = 14;
    localparam int TOTAL   = 60;

    logic       rst_n = 1'b0;
    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       full_n, afull_n, empty_n, aempty_n;
    logic       cfg_ld = 1'b0, cfg_sel = 1'b0;
    logic [AW-1:0] cfg_val = '0;

    int vectors = 0;
    int miscmp  = 0;
    logic [8:0] q[$];

    always #(CLK_W/2) wclk = ~wclk;
    always #(CLK_R/2) rclk = ~rclk;

    pfifo_pflag #(.DEPTH(DEPTH)) dut_i (
        .rst_n(rst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n), .rclk(rclk), .rd_en(rd_en),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n),
        .cfg_ld(cfg_ld), .cfg_sel(cfg_sel), .cfg_val(cfg_val)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic chk_flags(input int cnt, input int n, input int m);
        chk("R2 full_n",   int'(full_n),   int'(cnt != DEPTH));
        chk("R3 empty_n",  int'(empty_n),  int'(cnt != 0));
        chk("R4 afull_n",  int'(afull_n),  int'(cnt < DEPTH - m));
        chk("R5 aempty_n", int'(aempty_n), int'(cnt > n));
    endtask

    task automatic put(input logic [8:0] d);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic take(output logic [8:0] d);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic program_ofs(input int nv, input int mv);
        @(negedge wclk);
        cfg_ld = 1'b1; cfg_sel = 1'b0; cfg_val = AW'(nv);
        @(negedge wclk);
        cfg_sel = 1'b1; cfg_val = AW'(mv);
        @(negedge wclk);
        cfg_ld = 1'b0;
    endtask

    function automatic int clampv(input int v);
        if (v < 1) return 1;
        if (v > DEPTH - 2) return DEPTH - 2;
        return v;
    endfunction

    task automatic sweep(input int n, input int m, input int pass);
        logic [8:0] d;
        logic [8:0] held;
        for (int i = 1; i <= DEPTH; i++) begin
            d = 9'((pass * 37 + i * 11 + 5) & 9'h1FF);
            q.push_back(d);
            put(d);
            if (i == DEPTH) chk("R2 full at filling edge", int'(full_n), 0);
            settle();
            chk_flags(i, n, m);
        end
        put(9'h1AB);               // R2: ignored while full
        settle();
        chk_flags(DEPTH, n, m);
        for (int i = DEPTH - 1; i >= 0; i--) begin
            take(d);
            chk("R1 order", int'(d), int'(q.pop_front()));
            settle();
            chk_flags(i, n, m);
        end
        held = rd_data;
        take(d);                   // R3: ignored while empty
        chk("R3 rd_data held", int'(d), int'(held));
        settle();
        chk_flags(0, n, m);
    endtask

    initial begin : watchdog
        #(CLK_W * 150000);
        miscmp++;
        vectors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin : main
        logic [8:0] d;
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
        @(negedge rclk);
        // R6: reset state
        chk("R6 empty_n",  int'(empty_n),  0);
        chk("R6 aempty_n", int'(aempty_n), 0);
        chk("R6 full_n",   int'(full_n),   1);
        chk("R6 afull_n",  int'(afull_n),  1);

        // R6 default offsets of 7
        sweep(7, 7, 0);

        // R7 and R8: programmed and clamped offsets
        program_ofs(3, 10);  settle(); sweep(3, 10, 1);
        program_ofs(12, 2);  settle(); sweep(12, 2, 2);
        program_ofs(0, 0);   settle(); sweep(clampv(0), clampv(0), 3);
        program_ofs(15, 15); settle(); sweep(clampv(15), clampv(15), 4);

        // R7: load while not drained is ignored
        program_ofs(3, 3); settle();
        put(9'h011); q.push_back(9'h011); settle();
        program_ofs(1, 12); settle();
        put(9'h022); q.push_back(9'h022); settle();
        chk("R7 ignored n", int'(aempty_n), 0);   // n still 3, count 2
        chk("R7 ignored m", int'(afull_n), 1);    // m still 3
        take(d); chk("R1 order", int'(d), int'(q.pop_front()));
        take(d); chk("R1 order", int'(d), int'(q.pop_front()));
        settle();

        // R9: crossing latency bound
        put(9'h0F0); q.push_back(9'h0F0);
        repeat (4) @(negedge rclk);
        chk("R9 empty_n after write", int'(empty_n), 1);
        take(d);
        chk("R1 order", int'(d), int'(q.pop_front()));
        settle();

        // R1: free-running traffic on unrelated clocks
        fork
            begin : writer
                for (int i = 0; i < TOTAL; i++) begin
                    logic [8:0] v;
                    v = 9'((i * 29 + 3) & 9'h1FF);
                    do begin
                        @(negedge wclk);
                        wr_en = 1'b0;
                    end while (!full_n || (i % 5 == 2 && $urandom_range(0, 1) == 0));
                    wr_en = 1'b1; wr_data = v;
                    q.push_back(v);
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin : reader
                int got = 0;
                int cyc = 0;
                logic pend = 1'b0;
                while (got < TOTAL) begin
                    @(negedge rclk);
                    cyc++;
                    if (pend) begin
                        chk("R1 streaming order", int'(rd_data), int'(q.pop_front()));
                        got++;
                    end
                    pend = (got < TOTAL) && empty_n && (cyc % 4 != 3);
                    rd_en = pend;
                end
                rd_en = 1'b0;
            end
        join
        settle();
        chk_flags(0, 3, 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule